// File: doc/BRIEF.md
# Multi-Channel Data Mover Command and Result Front End

This block is the software-facing front end of a multi-channel data mover. Each channel takes a 32-bit command pointer over a simple register bus and says whether it can take another. When the transfer engine behind it finishes, the channel reports the outcome as a result word in a small per-channel queue. The transfer engine is outside the block. A stub engine drives per-channel done, flush and error inputs for the command in progress. Each channel answers a completion with an acknowledge, and that acknowledge may be held back while the result queue is full.

Every channel has a three-bit configuration. One bit enables the interrupt. One bit asks for a result word on normal completion. One bit asks for a result word on flush. An error always produces a result word. An error also locks the channel for good: it refuses all later commands. Flush and error events capture six engine state words into per-channel flush-state registers. A shared interrupt status register has one bit per channel and is cleared when it is read. The interrupt output is the OR of its bits.

Address map: address bit ADDR_W-1 set selects the global interrupt status. Otherwise bits [4 +: log2(NUM_CH)] select the channel and bits [3:0] select the register. Register 0 is the command pointer, 1 is status, 2 is the result queue, 3 is configuration, and 4 to 9 are flush-state words 0 to 5.

Top module: `cmdfe_top`

## Requirements
- R1: After reset, every channel status reads 0x1 (bit0 ready, bit1 result valid, bit2 locked). The result register reads 0, configuration reads 0, the global status reads 0 and irq is low. A write to configuration (bit0 irq enable, bit1 result on completion, bit2 result on flush) reads back its low three bits.
- R2: A write to register 0 of a ready channel makes issueVld a one-hot pulse for that channel in the next cycle, with issuePtr equal to the written value, and clears ready. A write to register 0 while the channel is busy is ignored.
- R3: A done event on a busy channel is acknowledged in the same cycle and makes the channel ready again. If configuration bit1 is 1, the result word 0x80000002 (bit31 and bit1) is queued. If bit1 is 0, no result is queued.
- R4: A flush event is acknowledged and loads the six flush-state words from engSnap, with word k taken from bits [32k +: 32]. The result word 0x4 (bit2) is queued only if configuration bit2 is 1.
- R5: An error event queues the result word 0x8 (bit3) whatever the configuration, loads the flush-state words, and locks the channel (status bit2, ready stays 0). After that, command writes start nothing, and writing 0 to flush-state word 0 neither unlocks the channel nor changes that word.
- R6: Reading register 2 returns the oldest queued word and removes it. Results come out in completion order, and a read of an empty queue returns 0 and removes nothing.
- R7: While a channel's result queue holds FIFO_DEPTH words, a completion that would queue a result is not acknowledged and the channel stays busy. It is taken in the cycle after a result is read out.
- R8: A queued result sets the channel's global status bit only if configuration bit0 is 1. Reading the global status returns all pending bits and clears them, and irq is high while any bit is set.
- R9: Engine events on a channel with no command in progress are not acknowledged and queue nothing.
- R10: A command, completion or lock on one channel leaves the status of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (applies read side effects) |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, combinational from regAddr |
| engDone | input | NUM_CH | Engine: command finished normally |
| engFlush | input | NUM_CH | Engine: command flushed |
| engError | input | NUM_CH | Engine: command failed |
| engSnap | input | 6*DATA_W | Engine state words captured on flush or error |
| engAck | output | NUM_CH | Completion taken this cycle |
| issueVld | output | NUM_CH | One-hot pulse: command started on that channel |
| issuePtr | output | DATA_W | Pointer of the last started command |
| irq | output | 1 | OR of global interrupt status bits |

## Verification
The bench builds the block with four channels and a result queue two entries deep. At that size every channel can be swept through all eight configuration values for both done and flush completions. A full queue is reached after two completions, so the held acknowledge and the in-order drain are cheap to reach. The small channel count also makes it practical to check, on every step, that neighbouring channels keep their status and that the global status bits clear on read.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam int IDX_W = 4;
  localparam int NFLUSH = 6;

  localparam logic [IDX_W-1:0] RG_CMD  = 4'd0;
  localparam logic [IDX_W-1:0] RG_STAT = 4'd1;
  localparam logic [IDX_W-1:0] RG_RSLT = 4'd2;
  localparam logic [IDX_W-1:0] RG_CFG  = 4'd3;
  localparam logic [IDX_W-1:0] RG_FL0  = 4'd4;

  localparam int CFG_IRQ = 0;
  localparam int CFG_TOP = 1;
  localparam int CFG_FLS = 2;

  localparam int FB_DONE  = 1;
  localparam int FB_FLUSH = 2;
  localparam int FB_ERR   = 3;

  typedef struct packed {
    logic issue;
    logic cfgWr;
    logic pop;
    logic push;
    logic snap;
    logic fDone;
    logic fFlush;
    logic fErr;
  } chStrobe_t;
endpackage

// File: rtl/cmdfe_ctrl.sv
module cmdfe_ctrl
  import cmdfe_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [NUM_CH-1:0]     engDone,
  input  logic [NUM_CH-1:0]     engFlush,
  input  logic [NUM_CH-1:0]     engError,
  input  logic [NUM_CH-1:0]     cfgTop,
  input  logic [NUM_CH-1:0]     cfgFlush,
  input  logic [NUM_CH-1:0]     fifoFull,
  input  logic [NUM_CH-1:0]     fifoEmpty,
  output chStrobe_t [NUM_CH-1:0] strb,
  output logic                  isrClr,
  output logic [NUM_CH-1:0]     chReady,
  output logic [NUM_CH-1:0]     chLocked,
  output logic [NUM_CH-1:0]     engAck
);
  logic             isGlobal;
  logic [IDX_W-1:0] regIdx;
  logic [CH_W-1:0]  regCh;

  assign isGlobal = regAddr[ADDR_W-1];
  assign regIdx   = regAddr[IDX_W-1:0];
  assign regCh    = regAddr[IDX_W +: CH_W];
  assign isrClr   = regRdEn && isGlobal;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, busy, locked, evt, needPush, accept, issueW;

    assign hit      = !isGlobal && (regCh == CH_W'(c));
    assign chReady[c]  = !busy && !locked;
    assign chLocked[c] = locked;
    assign evt      = busy && (engDone[c] || engFlush[c] || engError[c]);
    assign needPush = engError[c] || (engFlush[c] && cfgFlush[c]) ||
                      (engDone[c] && cfgTop[c]);
    // a full queue holds back only completions that must leave a word
    assign accept   = evt && (!needPush || !fifoFull[c]);
    assign engAck[c] = accept;
    assign issueW   = regWrEn && hit && (regIdx == RG_CMD) && !busy && !locked;

    assign strb[c] = '{
      issue:  issueW,
      cfgWr:  regWrEn && hit && (regIdx == RG_CFG),
      pop:    regRdEn && hit && (regIdx == RG_RSLT) && !fifoEmpty[c],
      push:   accept && needPush,
      snap:   accept && (engFlush[c] || engError[c]),
      fDone:  engDone[c],
      fFlush: engFlush[c],
      fErr:   engError[c]
    };

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busy   <= 1'b0;
        locked <= 1'b0;
      end else begin
        if (issueW)      busy <= 1'b1;
        else if (accept) busy <= 1'b0;
        if (accept && engError[c]) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdfe_dpath.sv
module cmdfe_dpath
  import cmdfe_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CH_W       = 4,
  parameter int ADDR_W     = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chStrobe_t [NUM_CH-1:0]   strb,
  input  logic                     isrClr,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  input  logic [NFLUSH*DATA_W-1:0] engSnap,
  input  logic [NUM_CH-1:0]        chReady,
  input  logic [NUM_CH-1:0]        chLocked,
  output logic [DATA_W-1:0]        regRdData,
  output logic [NUM_CH-1:0]        fifoFull,
  output logic [NUM_CH-1:0]        fifoEmpty,
  output logic [NUM_CH-1:0]        cfgTop,
  output logic [NUM_CH-1:0]        cfgFlush,
  output logic [NUM_CH-1:0]        issueVld,
  output logic [DATA_W-1:0]        issuePtr,
  output logic                     irq
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [NUM_CH-1:0][NFLUSH-1:0][DATA_W-1:0] flPk;
  logic [NUM_CH-1:0][DATA_W-1:0]             headPk;
  logic [NUM_CH-1:0][2:0]                    cfgPk;
  logic [NUM_CH-1:0]                         issueVec, irqSet;
  logic [NUM_CH-1:0]                         isr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0]                    cfg;
    logic [NFLUSH-1:0][DATA_W-1:0] fl;
    logic [DATA_W-1:0]             mem [FIFO_DEPTH];
    logic [PTR_W-1:0]              wp, rp;
    logic [CNT_W-1:0]              cnt;
    logic [DATA_W-1:0]             word;

    always_comb begin
      word           = '0;
      word[DATA_W-1] = strb[c].fDone;
      word[FB_DONE]  = strb[c].fDone;
      word[FB_FLUSH] = strb[c].fFlush;
      word[FB_ERR]   = strb[c].fErr;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg <= '0;
        fl  <= '0;
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (strb[c].cfgWr) cfg <= regWrData[2:0];
        if (strb[c].snap)  fl  <= engSnap;
        if (strb[c].push)  wp  <= nextPtr(wp);
        if (strb[c].pop)   rp  <= nextPtr(rp);
        cnt <= cnt + CNT_W'(strb[c].push) - CNT_W'(strb[c].pop);
      end
    end

    always_ff @(posedge clk) begin
      if (strb[c].push) mem[wp] <= word;
    end

    assign fifoFull[c]  = (cnt == CNT_W'(FIFO_DEPTH));
    assign fifoEmpty[c] = (cnt == '0);
    assign headPk[c]    = mem[rp];
    assign cfgPk[c]     = cfg;
    assign flPk[c]      = fl;
    assign cfgTop[c]    = cfg[CFG_TOP];
    assign cfgFlush[c]  = cfg[CFG_FLS];
    assign issueVec[c]  = strb[c].issue;
    assign irqSet[c]    = strb[c].push && cfg[CFG_IRQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueVld <= '0;
      issuePtr <= '0;
      isr      <= '0;
    end else begin
      issueVld <= issueVec;
      if (|issueVec) issuePtr <= regWrData;
      // a new completion in the clearing cycle survives the clear
      isr <= (isrClr ? '0 : isr) | irqSet;
    end
  end

  assign irq = |isr;

  logic [CH_W-1:0]  rdCh;
  logic [IDX_W-1:0] rdIdx;
  logic [2:0]       fsel;

  assign rdCh  = regAddr[IDX_W +: CH_W];
  assign rdIdx = regAddr[IDX_W-1:0];
  assign fsel  = 3'(rdIdx - RG_FL0);

  always_comb begin
    regRdData = '0;
    if (regAddr[ADDR_W-1]) begin
      regRdData = DATA_W'(isr);
    end else begin
      case (rdIdx)
        RG_STAT: begin
          regRdData[0] = chReady[rdCh];
          regRdData[1] = !fifoEmpty[rdCh];
          regRdData[2] = chLocked[rdCh];
        end
        RG_RSLT: regRdData = fifoEmpty[rdCh] ? '0 : headPk[rdCh];
        RG_CFG:  regRdData = DATA_W'(cfgPk[rdCh]);
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: regRdData = flPk[rdCh][fsel];
        default: regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdfe_top.sv
module cmdfe_top
  import cmdfe_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int ADDR_W    = CH_W + IDX_W + 1,
  localparam int SNAP_W    = NFLUSH * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] engDone,
  input  logic [NUM_CH-1:0] engFlush,
  input  logic [NUM_CH-1:0] engError,
  input  logic [SNAP_W-1:0] engSnap,
  output logic [NUM_CH-1:0] engAck,
  output logic [NUM_CH-1:0] issueVld,
  output logic [DATA_W-1:0] issuePtr,
  output logic              irq
);
  chStrobe_t [NUM_CH-1:0] strb;
  logic                   isrClr;
  logic [NUM_CH-1:0]      chReady, chLocked, fifoFull, fifoEmpty;
  logic [NUM_CH-1:0]      cfgTop, cfgFlush, pushVec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_push
    assign pushVec[c] = strb[c].push;
  end

  cmdfe_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .engDone(engDone), .engFlush(engFlush),
    .engError(engError), .cfgTop(cfgTop), .cfgFlush(cfgFlush),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .strb(strb),
    .isrClr(isrClr), .chReady(chReady), .chLocked(chLocked), .engAck(engAck)
  );

  cmdfe_dpath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH),
                .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .isrClr(isrClr),
    .regAddr(regAddr), .regWrData(regWrData), .engSnap(engSnap),
    .chReady(chReady), .chLocked(chLocked), .regRdData(regRdData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .cfgTop(cfgTop),
    .cfgFlush(cfgFlush), .issueVld(issueVld), .issuePtr(issuePtr), .irq(irq)
  );
endmodule

// File: rtl/cmdfe_chk.sv
module cmdfe_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] issueVld,
  input logic [NUM_CH-1:0] engAck,
  input logic [NUM_CH-1:0] engError,
  input logic [NUM_CH-1:0] chReady,
  input logic [NUM_CH-1:0] chLocked,
  input logic [NUM_CH-1:0] pushVec,
  input logic              isrClr,
  input logic              irq
);
  // R2: at most one channel starts per cycle
  p_onehot_issue_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueVld));

  // R5: a locked channel stays locked
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|chLocked) |=> ((chLocked & $past(chLocked)) == $past(chLocked)));

  // R5: no command starts on a channel that was locked
  p_no_issue_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|issueVld) |-> ((issueVld & $past(chLocked)) == '0));

  // R3: a non-error completion leaves the channel ready
  p_ready_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(engAck & ~engError)) |=> (($past(engAck & ~engError) & ~chReady) == '0));

  // R8: clearing with no new result drops the interrupt
  p_irq_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isrClr && !(|pushVec)) |=> !irq);
endmodule

bind cmdfe_top cmdfe_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .issueVld(issueVld), .engAck(engAck),
  .engError(engError), .chReady(chReady), .chLocked(chLocked),
  .pushVec(pushVec), .isrClr(isrClr), .irq(irq)
);

// File: tb/test_cmdfe_top.sv
module test_cmdfe_top;
  localparam int NCH = 4;
  localparam int DEP = 2;
  localparam int DW  = 32;
  localparam int CHW = 2;
  localparam int AW  = CHW + 5;
  localparam logic [AW-1:0] GADDR = AW'(1) << (AW - 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rstN = 1'b0;
  logic           regWrEn = 1'b0, regRdEn = 1'b0;
  logic [AW-1:0]  regAddr = '0;
  logic [DW-1:0]  regWrData = '0, regRdData;
  logic [NCH-1:0] engDone = '0, engFlush = '0, engError = '0;
  logic [6*DW-1:0] engSnap = '0;
  logic [NCH-1:0] engAck, issueVld;
  logic [DW-1:0]  issuePtr;
  logic           irq;

  cmdfe_top #(.NUM_CH(NCH), .DATA_W(DW), .FIFO_DEPTH(DEP)) i_cmdfe_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engDone(engDone), .engFlush(engFlush), .engError(engError),
    .engSnap(engSnap), .engAck(engAck), .issueVld(issueVld),
    .issuePtr(issuePtr), .irq(irq)
  );

  int nChk = 0, nBad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ca(input int ch, input int idx);
    return {1'b0, CHW'(ch), 4'(idx)};
  endfunction

  function automatic logic [31:0] snapVal(input int seed, input int k);
    return 32'hA500_0000 + 32'(seed * 16 + k);
  endfunction

  task automatic setSnap(input int seed);
    for (int k = 0; k < 6; k++) engSnap[k*DW +: DW] = snapVal(seed, k);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // kind 0 done, 1 flush, 2 error; one-cycle event
  task automatic evt(input int ch, input int kind, output logic ack);
    @(negedge clk);
    engDone[ch]  = (kind == 0);
    engFlush[ch] = (kind == 1);
    engError[ch] = (kind == 2);
    #1 ack = engAck[ch];
    @(negedge clk);
    engDone = '0; engFlush = '0; engError = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [31:0] ptr, word;
    bit push;
    int seed;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < NCH; ch++) begin
      rdChk("R1 status", ca(ch, 1), 32'h1);
      rdChk("R1 result", ca(ch, 2), 32'h0);
      rdChk("R1 config", ca(ch, 3), 32'h0);
    end
    rdChk("R1 global", GADDR, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // sweep: every channel, every config, done and flush
    for (int ch = 0; ch < NCH; ch++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int kind = 0; kind < 2; kind++) begin
          wr(ca(ch, 3), 32'hFFFF_FFF8 | 32'(cfg));
          rdChk("R1 config readback", ca(ch, 3), 32'(cfg));
          ptr = 32'h1000_0000 | 32'(ch << 8) | 32'(cfg << 4) | 32'(kind);
          wr(ca(ch, 0), ptr);
          chk("R2 issue one-hot", 32'(issueVld), 32'(1 << ch));
          chk("R2 issue pointer", issuePtr, ptr);
          rdChk("R2 busy status", ca(ch, 1), 32'h0);
          wr(ca(ch, 0), ~ptr);
          chk("R2 write while busy ignored", 32'(issueVld), 32'h0);
          for (int o = 0; o < NCH; o++)
            if (o != ch) rdChk("R10 neighbour status", ca(o, 1), 32'h1);
          seed = ch * 16 + cfg * 2 + kind;
          setSnap(seed);
          evt(ch, kind, ack);
          chk(kind == 0 ? "R3 done ack" : "R4 flush ack", 32'(ack), 32'h1);
          push = (kind == 0) ? cfg[1] : cfg[2];
          word = (kind == 0) ? 32'h8000_0002 : 32'h0000_0004;
          chk("R8 irq level", 32'(irq), 32'(push && cfg[0]));
          rdChk(kind == 0 ? "R3 status" : "R4 status", ca(ch, 1), {30'h0, push, 1'b1});
          if (push) begin
            rdChk(kind == 0 ? "R3 result word" : "R4 result word", ca(ch, 2), word);
            rdChk("R6 drained status", ca(ch, 1), 32'h1);
          end
          rdChk("R8 global read", GADDR, (push && cfg[0]) ? 32'(1 << ch) : 32'h0);
          rdChk("R8 global cleared", GADDR, 32'h0);
          if (kind == 1)
            for (int k = 0; k < 6; k++)
              rdChk("R4 flush state", ca(ch, 4 + k), snapVal(seed, k));
        end
      end
    end

    // R9: events on an idle channel
    evt(0, 0, ack);
    chk("R9 idle done not acked", 32'(ack), 32'h0);
    evt(0, 2, ack);
    chk("R9 idle error not acked", 32'(ack), 32'h0);
    rdChk("R9 idle status", ca(0, 1), 32'h1);
    rdChk("R9 idle result", ca(0, 2), 32'h0);

    // R6 / R7: queue order and full backpressure on channel 1
    wr(ca(1, 3), 32'h7);
    wr(ca(1, 0), 32'hA1);
    evt(1, 0, ack);
    wr(ca(1, 0), 32'hA2);
    evt(1, 1, ack);
    wr(ca(1, 0), 32'hA3);
    @(negedge clk);
    engDone[1] = 1'b1;
    #1 chk("R7 held when full", 32'(engAck[1]), 32'h0);
    @(negedge clk);
    #1 chk("R7 still held", 32'(engAck[1]), 32'h0);
    rdChk("R7 busy full status", ca(1, 1), 32'h2);
    rdChk("R6 first out", ca(1, 2), 32'h8000_0002);
    #1 chk("R7 taken after pop", 32'(engAck[1]), 32'h1);
    @(negedge clk);
    engDone[1] = 1'b0;
    rdChk("R6 second out", ca(1, 2), 32'h0000_0004);
    rdChk("R6 third out", ca(1, 2), 32'h8000_0002);
    rdChk("R6 empty read", ca(1, 2), 32'h0);
    rdChk("R6 final status", ca(1, 1), 32'h1);
    rdChk("R8 global ch1", GADDR, 32'h2);

    // R5: error lock on channel 2
    wr(ca(2, 3), 32'h0);
    wr(ca(2, 0), 32'hB0);
    setSnap(99);
    evt(2, 2, ack);
    chk("R5 error ack", 32'(ack), 32'h1);
    rdChk("R5 locked status", ca(2, 1), 32'h6);
    for (int k = 0; k < 6; k++) rdChk("R5 flush state", ca(2, 4 + k), snapVal(99, k));
    wr(ca(2, 0), 32'hB1);
    chk("R5 no issue when locked", 32'(issueVld), 32'h0);
    wr(ca(2, 4), 32'h0);
    rdChk("R5 still locked", ca(2, 1), 32'h6);
    rdChk("R5 flush0 unchanged", ca(2, 4), snapVal(99, 0));
    rdChk("R5 error word", ca(2, 2), 32'h0000_0008);
    rdChk("R5 locked empty", ca(2, 1), 32'h4);
    chk("R8 no irq without enable", 32'(irq), 32'h0);

    // R10: neighbour of a locked channel still works
    rdChk("R10 ch3 status", ca(3, 1), 32'h1);
    wr(ca(3, 3), 32'h3);
    wr(ca(3, 0), 32'hC0);
    chk("R10 ch3 issues", 32'(issueVld), 32'h8);
    evt(3, 0, ack);
    chk("R10 ch3 ack", 32'(ack), 32'h1);
    wr(ca(0, 3), 32'h3);
    wr(ca(0, 0), 32'hD0);
    evt(0, 0, ack);
    chk("R8 irq high", 32'(irq), 32'h1);
    rdChk("R8 two bits", GADDR, 32'h9);
    rdChk("R8 cleared", GADDR, 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);
    rdChk("R10 ch3 result", ca(3, 2), 32'h8000_0002);
    rdChk("R10 ch0 result", ca(0, 2), 32'h8000_0002);
    rdChk("R10 ch2 still locked", ca(2, 1), 32'h4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule